// File: doc/BRIEF.md
# Descriptor Table Register Instruction Unit

This unit executes the system-register instruction group selected by the 3-bit reg field of a decoded two-byte opcode. It holds the global and interrupt descriptor table registers (each a 16-bit limit and a 32-bit base) and the 32-bit control register 0. It carries out stores and loads of the two table registers, a store of the low half of control register 0 (the machine status word), and a load of the machine status word. The decoder in front of it supplies a start strobe, the reg field, a memory-form flag, a 16-bit register operand, the operand's byte address and the current privilege level.

Memory operands move through a byte-wide request/acknowledge port. Each byte travels in its own handshake, at consecutive addresses that start at the supplied operand address. Privilege and operand-form checks are settled before any memory access begins. A table register, or control register 0, changes only when the whole operation has succeeded. Every operation ends with a one-cycle done pulse. The pulse carries at most one of four flags: general-protection fault, invalid-opcode fault, memory error, or unimplemented operation.

Top module: `dtr_exec`

## Requirements
- R1: The reg field selects the operation: 0 stores the global table register, 1 stores the interrupt table register, 2 loads the global table register, 3 loads the interrupt table register, 4 stores the status word, 6 loads the status word and 7 is page invalidation.
- R2: Reg value 5 completes with the invalid-opcode flag and leaves all state unchanged.
- R3: A table register image is 6 bytes. Byte offsets 0 and 1 hold the limit and offsets 2 to 5 hold the base, each field least-significant byte first. Each byte moves in one handshake at operand address plus offset. A request stays raised until it is acknowledged.
- R4: Table stores and table loads in register form (memory flag 0) complete with the invalid-opcode flag and make no memory access.
- R5: Loads of either table register and loads of the status word at any privilege level other than 0 complete with the general-protection flag. This check comes before the operand-form check and before any memory access.
- R6: A status-word store writes control register 0 bits 15:0. In memory form it writes 2 bytes, low byte first. In register form it makes no memory access and pulses reg_wr with that value on reg_wdata, in the same cycle as done.
- R7: A status-word load copies operand bits 3:0 into control register 0 bits 3:0 and leaves bits 31:4 unchanged. In memory form the operand is the 2 bytes at the operand address, low byte first.
- R8: When control register 0 bit 0 is set and the new status word has bit 0 clear, the load completes with the general-protection flag and control register 0 is unchanged.
- R9: A memory error on any acknowledged byte ends the operation with the memory-error flag. A table load that ends this way leaves its table register unchanged.
- R10: Page invalidation (reg 7) completes with the unimplemented flag and changes no state.
- R11: Every operation ends with a done pulse one cycle wide. At most one flag is raised, and flags are raised only together with done.
- R12: After reset, both table limits are 0xFFFF, both bases are 0, control register 0 is 0x00000010, and done and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| op_sel | input | 3 | Reg field selecting the operation |
| is_mem | input | 1 | Operand is in memory (1) or a register (0) |
| cpl | input | 2 | Current privilege level |
| reg_opnd | input | 16 | Register-form operand for a status-word load |
| op_addr | input | 32 | Byte address of the memory operand |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_a | output | 32 | Byte address of the transfer |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes on this cycle |
| mem_err | input | 1 | Transfer failed, valid with mem_ack |
| done | output | 1 | One-cycle completion pulse |
| fault_gp | output | 1 | General-protection fault, with done |
| fault_ud | output | 1 | Invalid-opcode fault, with done |
| fault_mem | output | 1 | Memory error, with done |
| unimpl | output | 1 | Unsupported operation, with done |
| reg_wr | output | 1 | Register-form status-word result valid |
| reg_wdata | output | 16 | Register-form status-word result |
| gdtr_limit | output | 16 | Global table limit |
| gdtr_base | output | 32 | Global table base |
| idtr_limit | output | 16 | Interrupt table limit |
| idtr_base | output | 32 | Interrupt table base |
| cr0 | output | 32 | Control register 0 |

## Verification
The assertions assume three things about the inputs. start is raised only while the unit is idle and no done pulse is showing. mem_ack is never raised without mem_req. mem_err counts only together with an acknowledge. The bench keeps to these by issuing each operation from its task only after the previous done pulse has passed, and by driving the acknowledge from a memory model that follows mem_req. That model acknowledges either on every cycle or on every other cycle. It raises mem_err only while a request is open at one chosen address.

// File: rtl/dtr_pkg.sv
// Package: shared encodings for the descriptor table register unit.
// Assumes: the reg field is 3 bits and the status word is 16 bits wide.
package dtr_pkg;

    localparam int MSW_W = 16;

    typedef enum logic [2:0] {
        OP_ST_GTAB  = 3'd0,
        OP_ST_ITAB  = 3'd1,
        OP_LD_GTAB  = 3'd2,
        OP_LD_ITAB  = 3'd3,
        OP_ST_MSW   = 3'd4,
        OP_RSVD5    = 3'd5,
        OP_LD_MSW   = 3'd6,
        OP_INV_PAGE = 3'd7
    } dtr_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } dtr_state_e;

endpackage

// File: rtl/dtr_screen.sv
// Module: dtr_screen
// Classifies a requested operation before it starts: privilege fault,
// invalid-opcode fault, unsupported operation, whether memory is used,
// transfer length in bytes and transfer direction.
// Assumes: the privilege check has priority over the operand-form check.
module dtr_screen
    import dtr_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int TAB_BYTES = 6,
    parameter int MSW_BYTES = 2
) (
    input  logic [2:0]       op_sel,
    input  logic             is_mem,
    input  logic [1:0]       cpl,
    output logic             scr_gp,
    output logic             scr_ud,
    output logic             scr_un,
    output logic             scr_mem,
    output logic [LEN_W-1:0] scr_len,
    output logic             scr_store
);

    dtr_op_e op;
    logic    is_table;
    logic    is_priv;

    // Decode operation classes and apply checks in priority order.
    always_comb begin
        op        = dtr_op_e'(op_sel);
        is_table  = (op == OP_ST_GTAB) || (op == OP_ST_ITAB) ||
                    (op == OP_LD_GTAB) || (op == OP_LD_ITAB);
        is_priv   = (op == OP_LD_GTAB) || (op == OP_LD_ITAB) || (op == OP_LD_MSW);
        scr_gp    = is_priv && (cpl != 2'd0);
        scr_ud    = !scr_gp && ((op == OP_RSVD5) || (is_table && !is_mem));
        scr_un    = !scr_gp && !scr_ud && (op == OP_INV_PAGE);
        scr_mem   = !scr_gp && !scr_ud && !scr_un && is_mem;
        scr_len   = is_table ? LEN_W'(TAB_BYTES) : LEN_W'(MSW_BYTES);
        scr_store = (op == OP_ST_GTAB) || (op == OP_ST_ITAB) || (op == OP_ST_MSW);
    end

endmodule

// File: rtl/dtr_byte_lane.sv
// Module: dtr_byte_lane
// Byte sequencer for serial memory transfers: keeps the byte index,
// selects the outgoing write byte and collects incoming read bytes.
// merged shows the collected image with the byte arriving this cycle
// already in place, so a caller can commit on the last handshake.
// Assumes: clear and take are never raised together.
module dtr_byte_lane #(
    parameter int NBYTES = 6,
    parameter int IDX_W  = $clog2(NBYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                take,
    input  logic [7:0]          rdata,
    input  logic [8*NBYTES-1:0] wr_img,
    output logic [IDX_W-1:0]    idx,
    output logic [7:0]          wr_byte,
    output logic [8*NBYTES-1:0] merged
);

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       buf_q [NBYTES];

    // Byte index: restart on clear, step on each completed handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (clear) idx_q <= '0;
        else if (take)  idx_q <= idx_q + 1'b1;
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        // Capture the read byte that belongs to this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)                            buf_q[i] <= '0;
            else if (take && idx_q == IDX_W'(i))   buf_q[i] <= rdata;
        end
        assign merged[8*i +: 8] = (idx_q == IDX_W'(i)) ? rdata : buf_q[i];
    end

    assign idx     = idx_q;
    assign wr_byte = wr_img[8*idx_q +: 8];

endmodule

// File: rtl/dtr_exec.sv
// Module: dtr_exec (top)
// Executes the descriptor-table / status-word instruction group.
// Holds both table registers and control register 0, checks privilege,
// operand form and protected-mode exit, and moves memory operands one
// byte per request/acknowledge handshake, least-significant byte first.
// Assumes: start only while idle; mem_rdata and mem_err valid with mem_ack.
module dtr_exec
    import dtr_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              LIMIT_W     = 16,
    parameter int              BASE_W      = 32,
    parameter int              CR0_W       = 32,
    parameter logic [15:0]     LIMIT_RESET = 16'hFFFF,
    parameter logic [31:0]     BASE_RESET  = 32'h0000_0000,
    parameter logic [31:0]     CR0_RESET   = 32'h0000_0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op_sel,
    input  logic               is_mem,
    input  logic [1:0]         cpl,
    input  logic [MSW_W-1:0]   reg_opnd,
    input  logic [ADDR_W-1:0]  op_addr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_a,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    output logic               done,
    output logic               fault_gp,
    output logic               fault_ud,
    output logic               fault_mem,
    output logic               unimpl,
    output logic               reg_wr,
    output logic [MSW_W-1:0]   reg_wdata,
    output logic [LIMIT_W-1:0] gdtr_limit,
    output logic [BASE_W-1:0]  gdtr_base,
    output logic [LIMIT_W-1:0] idtr_limit,
    output logic [BASE_W-1:0]  idtr_base,
    output logic [CR0_W-1:0]   cr0
);

    localparam int IMG_W     = LIMIT_W + BASE_W;
    localparam int IMG_BYTES = IMG_W / 8;
    localparam int MSW_BYTES = MSW_W / 8;
    localparam int IDX_W     = $clog2(IMG_BYTES);
    localparam int LEN_W     = IDX_W + 1;

    dtr_state_e         state_q, state_d;
    dtr_op_e            op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   len_q;
    logic               store_q;
    logic [IMG_W-1:0]   wr_img_q, wr_img_d;

    logic [LIMIT_W-1:0] gl_q, il_q;
    logic [BASE_W-1:0]  gb_q, ib_q;
    logic [CR0_W-1:0]   cr0_q;

    logic               done_q, gp_q, ud_q, me_q, un_q, rw_q;
    logic [MSW_W-1:0]   rwd_q;

    logic               scr_gp, scr_ud, scr_un, scr_mem, scr_store;
    logic [LEN_W-1:0]   scr_len;

    logic [IDX_W-1:0]   idx;
    logic [7:0]         wr_byte;
    logic [IMG_W-1:0]   merged;

    logic               accept, hs, last;
    logic               fin, f_gp, f_ud, f_mem, f_un, rw;
    logic               ld_gdt, ld_idt, ld_msw;
    logic [MSW_W-1:0]   msw_src;
    logic               pe_exit;

    dtr_screen #(
        .LEN_W    (LEN_W),
        .TAB_BYTES(IMG_BYTES),
        .MSW_BYTES(MSW_BYTES)
    ) u_screen (
        .op_sel   (op_sel),
        .is_mem   (is_mem),
        .cpl      (cpl),
        .scr_gp   (scr_gp),
        .scr_ud   (scr_ud),
        .scr_un   (scr_un),
        .scr_mem  (scr_mem),
        .scr_len  (scr_len),
        .scr_store(scr_store)
    );

    dtr_byte_lane #(
        .NBYTES(IMG_BYTES),
        .IDX_W (IDX_W)
    ) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .take   (hs),
        .rdata  (mem_rdata),
        .wr_img (wr_img_q),
        .idx    (idx),
        .wr_byte(wr_byte),
        .merged (merged)
    );

    // Handshake, last-byte and protected-mode-exit detection.
    always_comb begin
        accept  = (state_q == ST_IDLE) && start;
        hs      = (state_q == ST_XFER) && mem_ack;
        last    = ({1'b0, idx} == (len_q - 1'b1));
        msw_src = (state_q == ST_IDLE) ? reg_opnd : merged[MSW_W-1:0];
        pe_exit = cr0_q[0] && !msw_src[0];
    end

    // Next state, completion flags and commit strobes.
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        f_gp    = 1'b0;
        f_ud    = 1'b0;
        f_mem   = 1'b0;
        f_un    = 1'b0;
        rw      = 1'b0;
        ld_gdt  = 1'b0;
        ld_idt  = 1'b0;
        ld_msw  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (scr_gp || scr_ud || scr_un) begin
                        fin  = 1'b1;
                        f_gp = scr_gp;
                        f_ud = scr_ud;
                        f_un = scr_un;
                    end else if (scr_mem) begin
                        state_d = ST_XFER;
                    end else if (dtr_op_e'(op_sel) == OP_ST_MSW) begin
                        fin = 1'b1;
                        rw  = 1'b1;
                    end else begin
                        fin    = 1'b1;
                        f_gp   = pe_exit;
                        ld_msw = !pe_exit;
                    end
                end
            end
            ST_XFER: begin
                if (hs) begin
                    if (mem_err) begin
                        fin     = 1'b1;
                        f_mem   = 1'b1;
                        state_d = ST_IDLE;
                    end else if (last) begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                        case (op_q)
                            OP_LD_GTAB: ld_gdt = 1'b1;
                            OP_LD_ITAB: ld_idt = 1'b1;
                            OP_LD_MSW: begin
                                f_gp   = pe_exit;
                                ld_msw = !pe_exit;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Image to be written for a store, taken from current state.
    always_comb begin
        case (dtr_op_e'(op_sel))
            OP_ST_GTAB: wr_img_d = {gb_q, gl_q};
            OP_ST_ITAB: wr_img_d = {ib_q, il_q};
            default:    wr_img_d = IMG_W'(cr0_q[MSW_W-1:0]);
        endcase
    end

    // Sequencing state and operand latches for one operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_ST_GTAB;
            addr_q   <= '0;
            len_q    <= '0;
            store_q  <= 1'b0;
            wr_img_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q     <= dtr_op_e'(op_sel);
                addr_q   <= op_addr;
                len_q    <= scr_len;
                store_q  <= scr_store;
                wr_img_q <= wr_img_d;
            end
        end
    end

    // Registered completion pulse, flags and register-form result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            gp_q   <= 1'b0;
            ud_q   <= 1'b0;
            me_q   <= 1'b0;
            un_q   <= 1'b0;
            rw_q   <= 1'b0;
            rwd_q  <= '0;
        end else begin
            done_q <= fin;
            gp_q   <= f_gp;
            ud_q   <= f_ud;
            me_q   <= f_mem;
            un_q   <= f_un;
            rw_q   <= rw;
            if (rw) rwd_q <= cr0_q[MSW_W-1:0];
        end
    end

    // Architectural registers, changed only on a successful commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gl_q  <= LIMIT_W'(LIMIT_RESET);
            gb_q  <= BASE_W'(BASE_RESET);
            il_q  <= LIMIT_W'(LIMIT_RESET);
            ib_q  <= BASE_W'(BASE_RESET);
            cr0_q <= CR0_W'(CR0_RESET);
        end else begin
            if (ld_gdt) begin
                gl_q <= merged[LIMIT_W-1:0];
                gb_q <= merged[IMG_W-1:LIMIT_W];
            end
            if (ld_idt) begin
                il_q <= merged[LIMIT_W-1:0];
                ib_q <= merged[IMG_W-1:LIMIT_W];
            end
            if (ld_msw) cr0_q[3:0] <= msw_src[3:0];
        end
    end

    assign mem_req    = (state_q == ST_XFER);
    assign mem_we     = store_q;
    assign mem_a      = addr_q + ADDR_W'(idx);
    assign mem_wdata  = wr_byte;
    assign done       = done_q;
    assign fault_gp   = gp_q;
    assign fault_ud   = ud_q;
    assign fault_mem  = me_q;
    assign unimpl     = un_q;
    assign reg_wr     = rw_q;
    assign reg_wdata  = rwd_q;
    assign gdtr_limit = gl_q;
    assign gdtr_base  = gb_q;
    assign idtr_limit = il_q;
    assign idtr_base  = ib_q;
    assign cr0        = cr0_q;

endmodule

// File: rtl/dtr_exec_checker.sv
// Module: dtr_exec_checker
// Temporal checks on the descriptor table register unit, bound to its top.
// Assumes: mem_ack only with mem_req; start only while idle.
module dtr_exec_checker #(
    parameter int LIMIT_W = 16,
    parameter int BASE_W  = 32,
    parameter int CR0_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               fault_gp,
    input logic               fault_ud,
    input logic               fault_mem,
    input logic               unimpl,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [LIMIT_W-1:0] gdtr_limit,
    input logic [BASE_W-1:0]  gdtr_base,
    input logic [CR0_W-1:0]   cr0
);

    // R11: flags appear only on a done pulse.
    p_flag_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp || fault_ud || fault_mem || unimpl) |-> done);

    // R11: never more than one flag at a time.
    p_single_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_gp, fault_ud, fault_mem, unimpl}));

    // R8: once protection is on, a status-word load cannot clear it.
    p_pe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cr0[0] |=> cr0[0]);

    // R7: upper control register bits never move.
    p_cr0_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cr0[CR0_W-1:4]));

    // R4: an invalid-opcode fault is raised without any memory request.
    p_ud_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_ud) |-> !$past(mem_req));

    // R9: the global table changes only on a clean completion.
    p_gdt_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({gdtr_limit, gdtr_base}) |-> (done && !fault_mem && !fault_gp));

    // R3: a request is held until acknowledged.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

endmodule

bind dtr_exec dtr_exec_checker #(
    .LIMIT_W(LIMIT_W),
    .BASE_W (BASE_W),
    .CR0_W  (CR0_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .fault_gp  (fault_gp),
    .fault_ud  (fault_ud),
    .fault_mem (fault_mem),
    .unimpl    (unimpl),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .gdtr_limit(gdtr_limit),
    .gdtr_base (gdtr_base),
    .cr0       (cr0)
);

// File: tb/dtr_exec_test.sv
`timescale 1ns/1ps
// Bench for dtr_exec: sweeps every reg value, operand form and two
// privilege levels under two acknowledge patterns, then runs targeted
// protection-exit and memory-error cases against an arithmetic model.
module dtr_exec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        is_mem = 1'b0;
    logic [1:0]  cpl = '0;
    logic [15:0] reg_opnd = '0;
    logic [31:0] op_addr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_a;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;
    logic        mem_err;
    logic        done, fault_gp, fault_ud, fault_mem, unimpl, reg_wr;
    logic [15:0] reg_wdata, gdtr_limit, idtr_limit;
    logic [31:0] gdtr_base, idtr_base, cr0;

    logic        stall_mode = 1'b0;
    logic        err_en = 1'b0;
    logic [7:0]  err_addr = '0;
    logic [7:0]  mem [256];
    int          hs_cnt = 0;
    int          n_chk = 0;
    int          n_err = 0;

    logic [15:0] m_gl = 16'hFFFF, m_il = 16'hFFFF;
    logic [31:0] m_gb = '0, m_ib = '0, m_cr0 = 32'h10;

    always #4 clk = ~clk;

    dtr_exec uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .is_mem(is_mem),
        .cpl(cpl), .reg_opnd(reg_opnd), .op_addr(op_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_a(mem_a), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .done(done), .fault_gp(fault_gp),
        .fault_ud(fault_ud), .fault_mem(fault_mem), .unimpl(unimpl), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .gdtr_limit(gdtr_limit), .gdtr_base(gdtr_base),
        .idtr_limit(idtr_limit), .idtr_base(idtr_base), .cr0(cr0)
    );

    // Memory model: pattern fill during reset, byte writes on handshake.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
        end else if (mem_req && mem_ack && mem_we) begin
            mem[mem_a[7:0]] <= mem_wdata;
        end
        if (mem_req && mem_ack) hs_cnt <= hs_cnt + 1;
    end

    // Acknowledge: every cycle, or every other cycle in stall mode.
    always @(negedge clk) mem_ack <= mem_req && (stall_mode ? !mem_ack : 1'b1);

    assign mem_rdata = mem[mem_a[7:0]];
    assign mem_err   = err_en && mem_req && (mem_a[7:0] == err_addr);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic m, input logic [1:0] c,
                         input logic [15:0] opnd, input logic [7:0] a);
        bit          priv, e_gp, e_ud, e_un, e_fm, e_rw, memp, pe_f, ok;
        int          len, e_hs, hs0, k;
        logic [15:0] e_rd, val;
        logic [7:0]  img [6];
        logic [3:0]  fl;
        string       tag;
        priv = (op == 3'd2) || (op == 3'd3) || (op == 3'd6);
        e_gp = priv && (c != 2'd0);
        e_ud = !e_gp && ((op == 3'd5) || ((op <= 3'd3) && !m));
        e_un = !e_gp && !e_ud && (op == 3'd7);
        memp = !e_gp && !e_ud && !e_un && m;
        len  = (op <= 3'd3) ? 6 : 2;
        e_hs = memp ? len : 0;
        e_fm = 1'b0;
        pe_f = 1'b0;
        if (memp && err_en && (err_addr >= a) && (int'(err_addr) < int'(a) + len)) begin
            e_fm = 1'b1;
            e_hs = int'(err_addr) - int'(a) + 1;
        end
        e_rw = !e_gp && !e_ud && !e_un && !m && (op == 3'd4);
        e_rd = m_cr0[15:0];
        for (int i = 0; i < 6; i++) img[i] = '0;
        if (!(e_gp || e_ud || e_un || e_fm)) begin
            case (op)
                3'd0: for (int i = 0; i < 6; i++) img[i] = 8'({m_gb, m_gl} >> (8 * i));
                3'd1: for (int i = 0; i < 6; i++) img[i] = 8'({m_ib, m_il} >> (8 * i));
                3'd4: begin img[0] = m_cr0[7:0]; img[1] = m_cr0[15:8]; end
                3'd2: begin
                    m_gl = {mem[8'(a + 1)], mem[a]};
                    m_gb = {mem[8'(a + 5)], mem[8'(a + 4)], mem[8'(a + 3)], mem[8'(a + 2)]};
                end
                3'd3: begin
                    m_il = {mem[8'(a + 1)], mem[a]};
                    m_ib = {mem[8'(a + 5)], mem[8'(a + 4)], mem[8'(a + 3)], mem[8'(a + 2)]};
                end
                3'd6: begin
                    val = m ? {mem[8'(a + 1)], mem[a]} : opnd;
                    if (m_cr0[0] && !val[0]) begin e_gp = 1'b1; pe_f = 1'b1; end
                    else m_cr0[3:0] = val[3:0];
                end
                default: ;
            endcase
        end
        if (e_fm) tag = "R9";
        else if (pe_f) tag = "R8";
        else if (e_gp) tag = "R5";
        else if (e_ud && op == 3'd5) tag = "R2";
        else if (e_ud) tag = "R4";
        else if (e_un) tag = "R10";
        else tag = "R1";

        @(negedge clk);
        start = 1'b1; op_sel = op; is_mem = m; cpl = c; reg_opnd = opnd; op_addr = {24'h0, a};
        hs0 = hs_cnt;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 200) begin @(negedge clk); k++; end
        chk(done, {tag, " done"}, 64'(done), 64'd1);
        fl = {fault_gp, fault_ud, fault_mem, unimpl};
        chk(fl == {e_gp, e_ud, e_fm, e_un}, {tag, " flags"}, 64'(fl), 64'({e_gp, e_ud, e_fm, e_un}));
        chk((hs_cnt - hs0) == e_hs, memp ? "R3 byte count" : "R4 no memory access",
            64'(hs_cnt - hs0), 64'(e_hs));
        chk({gdtr_limit, gdtr_base} == {m_gl, m_gb}, {tag, " global table"},
            64'({gdtr_limit, gdtr_base}), 64'({m_gl, m_gb}));
        chk({idtr_limit, idtr_base} == {m_il, m_ib}, {tag, " interrupt table"},
            64'({idtr_limit, idtr_base}), 64'({m_il, m_ib}));
        chk(cr0 == m_cr0, "R7 control register", 64'(cr0), 64'(m_cr0));
        chk(reg_wr == e_rw, "R6 reg_wr", 64'(reg_wr), 64'(e_rw));
        if (e_rw) chk(reg_wdata == e_rd, "R6 reg_wdata", 64'(reg_wdata), 64'(e_rd));
        if (memp && !e_fm && (op == 3'd0 || op == 3'd1 || op == 3'd4)) begin
            ok = 1'b1;
            for (int i = 0; i < len; i++) if (mem[8'(a + i)] !== img[i]) ok = 1'b0;
            chk(ok, (op == 3'd4) ? "R6 stored word" : "R3 stored image",
                64'(mem[a]), 64'(img[0]));
        end
        @(negedge clk);
        chk(!done, "R11 done width", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({gdtr_limit, gdtr_base, idtr_limit, idtr_base} == {16'hFFFF, 32'h0, 16'hFFFF, 32'h0},
            "R12 table reset", 64'({gdtr_limit, gdtr_base}), {16'hFFFF, 48'h0});
        chk(cr0 == 32'h10, "R12 control reset", 64'(cr0), 64'h10);
        chk(!done && !mem_req, "R12 idle outputs", 64'({done, mem_req}), 64'd0);

        for (int s = 0; s < 2; s++) begin
            stall_mode = s[0];
            for (int op = 0; op < 8; op++)
                for (int m = 0; m < 2; m++)
                    for (int ci = 0; ci < 2; ci++)
                        do_op(3'(op), m[0], ci[0] ? 2'd3 : 2'd0,
                              16'(16'h1230 + op * 3 + m + ci * 5),
                              8'(op * 24 + m * 12 + s * 3));
        end

        stall_mode = 1'b0;
        do_op(3'd6, 1'b0, 2'd0, 16'h000B, 8'h00);
        do_op(3'd6, 1'b0, 2'd0, 16'hFFF4, 8'h00);
        do_op(3'd6, 1'b0, 2'd0, 16'h0003, 8'h00);
        do_op(3'd4, 1'b1, 2'd3, 16'h0000, 8'hC0);
        do_op(3'd6, 1'b1, 2'd0, 16'h0000, 8'hC0);
        do_op(3'd6, 1'b1, 2'd0, 16'h0000, 8'h40);
        err_en = 1'b1;
        err_addr = 8'hD3;
        do_op(3'd2, 1'b1, 2'd0, 16'h0000, 8'hD0);
        stall_mode = 1'b1;
        do_op(3'd3, 1'b1, 2'd0, 16'h0000, 8'hCE);
        err_en = 1'b0;
        do_op(3'd3, 1'b1, 2'd0, 16'h0000, 8'hCE);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule